// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of a behavioural model of an extended-data-out DRAM. Every clock it samples the row strobe, one column strobe per data lane, the write strobe and the output enable, all active low. From these pins, and from the order in which they fell, it decides what kind of memory cycle is in progress. The possible cycles are idle standby, three refresh flavours, a plain read, three write flavours and error.

The result is registered. The decoder reports a cycle class code, a per-lane read flag, a per-lane write flag and a per-lane output-driver enable. An array model uses the lane flags to move data. The pad logic uses the driver enables to turn the DQ outputs on or off. Illegal pin combinations raise an error flag and keep every driver off.

The decision does not rest on the present pin levels alone. At each first column strobe fall, the block latches whether write was already low. It also records whether read data has been driven during the current column cycle, and whether a column strobe was held low out of a read while the row strobe went high. With these records it can tell an early write from a delayed write or a read-modify-write, a column-before-row refresh from a hidden refresh, and two lanes that were started in different modes.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While the row strobe is high, the class is standby (code 0). No lane reads, no lane writes, no driver is enabled and there is no error, whatever the other pins do.
- R2: A row strobe fall with every column strobe high gives class 1 (row-only refresh). The class stays 1 until a column strobe falls, and the drivers stay off.
- R3: A row strobe fall while a column strobe is already low, with no read held over, gives class 2 (column-before-row refresh) until the row strobe rises. No lane is active during that time.
- R4: If a column strobe stays low from a read in which data was driven, the row strobe rises, and the row strobe then falls again, the class is 3 (hidden refresh) and no lane is active.
- R5: During a column access, if write is high and output enable is low, each lane whose column strobe is low (bit i follows column strobe i) is flagged as read and gets its driver enabled. This is class 4. Lanes whose column strobe is high stay idle.
- R6: If write is already low when the first column strobe of a column cycle falls, the cycle is class 5 (early write) and the selected lanes are written. The drivers stay off for that whole column cycle, even if output enable later goes low with write high.
- R7: If write falls after the column strobe in a column cycle where no data has been driven, the class becomes 6 (delayed write) and the selected lanes are written.
- R8: If write falls after read data has been driven in the same column cycle, the class becomes 7 (read-modify-write). Read flags appear first and write flags follow.
- R9: If one selected lane was started with write high and another with write low in the same column cycle, the error flag is set. The class reads 0 and all lane outputs are 0.
- R10: During a column access, write low together with output enable low sets the error flag, with class 0 and all lane outputs 0.
- R11: In page mode, while every column strobe is high inside a row cycle, no lane is active and the class keeps the last column cycle's code. The next first column strobe fall decides the mode again.
- R12: Outputs follow the pins sampled at a clock edge, registered at that same edge. A synchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Column strobe per lane, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_class | output | 3 | Cycle class code, as listed in the requirements |
| lane_rd | output | LANES | Lane is being read |
| lane_wr | output | LANES | Lane is being written |
| dq_oe | output | LANES | Lane DQ driver enable |
| cyc_err | output | 1 | Illegal strobe combination |

## Verification
Most of the hidden state is ordering memory: the latched mode per lane, the read-seen record and the held-read record. If any of these is wrong, the wrong class code shows at the ports one clock after the edge that should have used it. Typical symptoms are write-after-read reported as delayed write instead of read-modify-write, hidden refresh reported as column-before-row refresh, or a stale per-lane mode raising or missing the error flag when the second lane's strobe falls. A wrong phase record shows up as drivers enabled during refresh or during an early write. The vectors walk each ordering through its deciding edge and check the very next output.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM strobe cycle decoder.
// Assumes the class codes below are the values visible at the top port.
package dcd_pkg;

    typedef enum logic [2:0] {
        CYC_STANDBY  = 3'd0,
        CYC_RFSH_ROW = 3'd1,
        CYC_RFSH_COL = 3'd2,
        CYC_RFSH_HID = 3'd3,
        CYC_READ     = 3'd4,
        CYC_WR_EARLY = 3'd5,
        CYC_WR_LATE  = 3'd6,
        CYC_RMW      = 3'd7
    } cyc_class_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ROWONLY = 3'd1,
        PH_COLROW  = 3'd2,
        PH_HIDDEN  = 3'd3,
        PH_ACCESS  = 3'd4
    } phase_e;

endpackage

// File: rtl/dcd_pin_history.sv
`timescale 1ns/1ps
// Keeps the previous sample of the row and column strobes and derives the
// edge events the classifier needs. Assumes pins are already synchronous
// to clk. Reset values are "strobes high", so a row strobe that is low when
// reset lifts counts as a fresh fall.
module dcd_pin_history #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    output logic             ras_prev_n,
    output logic             ras_fall,
    output logic [LANES-1:0] cas_fall,
    output logic             any_cas,
    output logic             first_cas_fall
);

    logic [LANES-1:0] cas_prev_n;

    // Register the previous strobe levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev_n <= 1'b1;
            cas_prev_n <= '1;
        end else begin
            ras_prev_n <= ras_n;
            cas_prev_n <= cas_n;
        end
    end

    // Derive edge events from the previous and present levels.
    always_comb begin
        ras_fall       = ras_prev_n & ~ras_n;
        cas_fall       = cas_prev_n & ~cas_n;
        any_cas        = |(~cas_n);
        first_cas_fall = (&cas_prev_n) & any_cas;
    end

endmodule

// File: rtl/dcd_lane_mode.sv
`timescale 1ns/1ps
// Per-lane record of the mode a lane was started in: whether write was low
// when that lane's column strobe fell. Flags a conflict when the lanes that
// are selected now were started in different modes. Assumes cas_fall comes
// from the pin history of the same cycle.
module dcd_lane_mode #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] cas_fall,
    input  logic [LANES-1:0] sel,
    input  logic             we_n,
    output logic             conflict
);

    logic [LANES-1:0] early_q;
    logic [LANES-1:0] early_cur;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Select the mode of lane i: freshly sampled on its fall, otherwise held.
        always_comb begin
            early_cur[i] = cas_fall[i] ? ~we_n : early_q[i];
        end

        // Hold the mode of lane i between its strobe falls.
        always_ff @(posedge clk) begin
            if (!rst_n) early_q[i] <= 1'b0;
            else        early_q[i] <= early_cur[i];
        end
    end

    // Conflict when the selected lanes include both modes.
    always_comb begin
        conflict = (|(sel & early_cur)) & (|(sel & ~early_cur));
    end

endmodule

// File: rtl/dcd_cycle_fsm.sv
`timescale 1ns/1ps
// Tracks the row-cycle phase, the column-cycle mode, whether read data was
// driven, and whether a column strobe is being held out of a read. From
// these records and the present pins it produces the unregistered cycle
// class and the lane flags. Assumes edge events from dcd_pin_history.
module dcd_cycle_fsm
    import dcd_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             ras_prev_n,
    input  logic             ras_fall,
    input  logic             any_cas,
    input  logic             first_cas_fall,
    input  logic             lane_conflict,
    output cyc_class_e       cls_cur,
    output logic [LANES-1:0] rd_cur,
    output logic [LANES-1:0] wr_cur,
    output logic             err_cur
);

    phase_e     phase_q, phase_cur;
    cyc_class_e mode_q, mode_cur;
    logic       rd_seen_q, rd_seen_cur;
    logic       hold_q, hold_cur;
    logic [LANES-1:0] sel;
    logic       in_access, col_start, read_now;

    // Lanes whose column strobe is low.
    assign sel = ~cas_n;

    // Next row-cycle phase from the row strobe and the column strobe order.
    always_comb begin
        if (ras_n)
            phase_cur = PH_IDLE;
        else if (ras_fall)
            phase_cur = any_cas ? (hold_q ? PH_HIDDEN : PH_COLROW) : PH_ROWONLY;
        else if (phase_q == PH_ROWONLY && any_cas)
            phase_cur = PH_ACCESS;
        else
            phase_cur = phase_q;
    end

    assign in_access = (phase_cur == PH_ACCESS);
    assign col_start = in_access & first_cas_fall;

    // Column-cycle mode: chosen at the first strobe fall, upgraded when write falls late.
    always_comb begin
        if (col_start)
            mode_cur = we_n ? CYC_READ : CYC_WR_EARLY;
        else if (in_access && mode_q == CYC_READ && !we_n && any_cas)
            mode_cur = rd_seen_q ? CYC_RMW : CYC_WR_LATE;
        else
            mode_cur = mode_q;
    end

    // Error detection during an access.
    always_comb begin
        err_cur = in_access & any_cas & ((~we_n & ~oe_n) | lane_conflict);
    end

    // Lane flags for the present sample.
    always_comb begin
        read_now = in_access & ~err_cur & (mode_cur != CYC_WR_EARLY) & we_n & ~oe_n & any_cas;
        rd_cur   = read_now ? sel : '0;
        wr_cur   = (in_access & ~err_cur & ~we_n) ? sel : '0;
    end

    // Record of read data driven within the present column cycle.
    always_comb begin
        if (col_start)
            rd_seen_cur = read_now;
        else
            rd_seen_cur = in_access & (rd_seen_q | read_now);
    end

    // Record of a column strobe held low out of a read across a row precharge.
    always_comb begin
        if (ras_n)
            hold_cur = any_cas & (hold_q |
                       (~ras_prev_n & phase_q == PH_ACCESS & mode_q == CYC_READ & rd_seen_q));
        else
            hold_cur = 1'b0;
    end

    // Class code for the present sample.
    always_comb begin
        case (phase_cur)
            PH_ROWONLY: cls_cur = CYC_RFSH_ROW;
            PH_COLROW:  cls_cur = CYC_RFSH_COL;
            PH_HIDDEN:  cls_cur = CYC_RFSH_HID;
            PH_ACCESS:  cls_cur = err_cur ? CYC_STANDBY : mode_cur;
            default:    cls_cur = CYC_STANDBY;
        endcase
    end

    // Update the tracking records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            mode_q    <= CYC_STANDBY;
            rd_seen_q <= 1'b0;
            hold_q    <= 1'b0;
        end else begin
            phase_q   <= phase_cur;
            mode_q    <= mode_cur;
            rd_seen_q <= rd_seen_cur;
            hold_q    <= hold_cur;
        end
    end

endmodule

// File: rtl/dram_strobe_decoder.sv
`timescale 1ns/1ps
// Classifies the DRAM strobe cycle per clock and drives the registered
// class, lane read/write flags, driver enables and error flag.
// Assumes all strobes are synchronous to clk and active low.
module dram_strobe_decoder
    import dcd_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic [2:0]       cyc_class,
    output logic [LANES-1:0] lane_rd,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] dq_oe,
    output logic             cyc_err
);

    logic             ras_prev_n, ras_fall, any_cas, first_cas_fall, lane_conflict;
    logic [LANES-1:0] cas_fall;
    cyc_class_e       cls_cur;
    logic [LANES-1:0] rd_cur, wr_cur;
    logic             err_cur;

    dcd_pin_history #(.LANES(LANES)) u_hist (
        .clk            (clk),
        .rst_n          (rst_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .ras_prev_n     (ras_prev_n),
        .ras_fall       (ras_fall),
        .cas_fall       (cas_fall),
        .any_cas        (any_cas),
        .first_cas_fall (first_cas_fall)
    );

    dcd_lane_mode #(.LANES(LANES)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas_fall (cas_fall),
        .sel      (~cas_n),
        .we_n     (we_n),
        .conflict (lane_conflict)
    );

    dcd_cycle_fsm #(.LANES(LANES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n),
        .oe_n           (oe_n),
        .ras_prev_n     (ras_prev_n),
        .ras_fall       (ras_fall),
        .any_cas        (any_cas),
        .first_cas_fall (first_cas_fall),
        .lane_conflict  (lane_conflict),
        .cls_cur        (cls_cur),
        .rd_cur         (rd_cur),
        .wr_cur         (wr_cur),
        .err_cur        (err_cur)
    );

    // Register the decoded outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_class <= 3'd0;
            lane_rd   <= '0;
            lane_wr   <= '0;
            dq_oe     <= '0;
            cyc_err   <= 1'b0;
        end else begin
            cyc_class <= cls_cur;
            lane_rd   <= rd_cur;
            lane_wr   <= wr_cur;
            dq_oe     <= rd_cur;
            cyc_err   <= err_cur;
        end
    end

endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
// Port-level properties of the strobe decoder, attached by bind.
module dcd_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic [2:0]       cyc_class,
    input logic [LANES-1:0] lane_rd,
    input logic [LANES-1:0] lane_wr,
    input logic [LANES-1:0] dq_oe,
    input logic             cyc_err
);

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ras_n)) |-> (cyc_class == 3'd0 && dq_oe == '0 && lane_wr == '0 && !cyc_err)); // R1

    AST_OE_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((dq_oe & $past(cas_n)) == '0)); // R5

    AST_EARLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_class == 3'd5) |-> (dq_oe == '0)); // R6

    AST_WR_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && lane_wr != '0) |-> !$past(we_n)); // R7

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_rd & lane_wr) == '0)); // R8

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_err |-> (dq_oe == '0 && lane_wr == '0 && cyc_class == 3'd0)); // R10

    AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_class inside {3'd1, 3'd2, 3'd3}) |-> (dq_oe == '0 && lane_wr == '0)); // R3

endmodule

bind dram_strobe_decoder dcd_checker #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cyc_class (cyc_class),
    .lane_rd   (lane_rd),
    .lane_wr   (lane_wr),
    .dq_oe     (dq_oe),
    .cyc_err   (cyc_err)
);

// File: tb/dram_strobe_decoder_bench.sv
`timescale 1ns/1ps
module dram_strobe_decoder_bench;

    typedef struct packed {
        logic [2:0] cls;
        logic [1:0] rd;
        logic [1:0] wr;
        logic [1:0] oe;
        logic       err;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b0;
    logic [1:0] cas_n = 2'b00;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [2:0] cyc_class;
    logic [1:0] lane_rd, lane_wr, dq_oe;
    logic       cyc_err;

    exp_t  exp_q[$];
    string tag_q[$];
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    dram_strobe_decoder #(.LANES(2)) u_dram_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .cyc_class(cyc_class),
        .lane_rd(lane_rd), .lane_wr(lane_wr), .dq_oe(dq_oe), .cyc_err(cyc_err)
    );

    // Driver: apply pins on the falling edge and queue the expected result.
    task automatic vec(input logic r, input logic [1:0] c, input logic w, input logic o,
                       input logic [2:0] ecls, input logic [1:0] erd, input logic [1:0] ewr,
                       input logic [1:0] eoe, input logic eerr, input string tag);
        exp_t e;
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
        e.cls = ecls; e.rd = erd; e.wr = ewr; e.oe = eoe; e.err = eerr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after the edge that registered the queued vector.
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            exp_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{cls: cyc_class, rd: lane_rd, wr: lane_wr, oe: dq_oe, err: cyc_err};
            vectors++;
            if (a !== e) begin
                miscompares++;
                $display("FAIL %s actual cls=%0d rd=%b wr=%b oe=%b err=%b expected cls=%0d rd=%b wr=%b oe=%b err=%b",
                         t, a.cls, a.rd, a.wr, a.oe, a.err, e.cls, e.rd, e.wr, e.oe, e.err);
            end
        end
    end

    initial begin
        // R12: reset clears outputs although the pins ask for a read
        vec(0, 2'b00, 1, 0, 0, 2'b00, 2'b00, 2'b00, 0, "R12");
        vec(0, 2'b00, 1, 0, 0, 2'b00, 2'b00, 2'b00, 0, "R12");
        @(negedge clk);
        rst_n = 1'b1; ras_n = 1; cas_n = 2'b11; we_n = 1; oe_n = 1;
        // R1: standby regardless of other pins
        vec(1, 2'b00, 0, 0, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R2: row-only refresh
        vec(0, 2'b11, 1, 1, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(0, 2'b11, 1, 0, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R3: column strobe ahead of row strobe
        vec(1, 2'b10, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        vec(0, 2'b10, 1, 1, 2, 2'b00, 2'b00, 2'b00, 0, "R3");
        vec(0, 2'b00, 1, 0, 2, 2'b00, 2'b00, 2'b00, 0, "R3");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R5: read, lane 0 then both lanes
        vec(0, 2'b11, 1, 1, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(0, 2'b10, 1, 0, 4, 2'b01, 2'b00, 2'b01, 0, "R5");
        vec(0, 2'b00, 1, 0, 4, 2'b11, 2'b00, 2'b11, 0, "R5");
        // R4: hold column strobes low through a row precharge
        vec(1, 2'b00, 1, 0, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        vec(0, 2'b00, 1, 1, 3, 2'b00, 2'b00, 2'b00, 0, "R4");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R6: early write, then output enable low must not drive
        vec(0, 2'b11, 1, 1, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(0, 2'b00, 0, 1, 5, 2'b00, 2'b11, 2'b00, 0, "R6");
        vec(0, 2'b00, 1, 0, 5, 2'b00, 2'b00, 2'b00, 0, "R6");
        // R11: page precharge keeps class, then new column cycle re-decides
        vec(0, 2'b11, 1, 1, 5, 2'b00, 2'b00, 2'b00, 0, "R11");
        vec(0, 2'b01, 1, 1, 4, 2'b00, 2'b00, 2'b00, 0, "R11");
        // R7: delayed write on lane 1
        vec(0, 2'b01, 0, 1, 6, 2'b00, 2'b10, 2'b00, 0, "R7");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R8: read-modify-write
        vec(0, 2'b11, 1, 1, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(0, 2'b00, 1, 0, 4, 2'b11, 2'b00, 2'b11, 0, "R8");
        vec(0, 2'b00, 1, 1, 4, 2'b00, 2'b00, 2'b00, 0, "R8");
        vec(0, 2'b00, 0, 1, 7, 2'b00, 2'b11, 2'b00, 0, "R8");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R9: lanes started in different modes
        vec(0, 2'b11, 1, 1, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(0, 2'b10, 1, 1, 4, 2'b00, 2'b00, 2'b00, 0, "R9");
        vec(0, 2'b00, 0, 1, 0, 2'b00, 2'b00, 2'b00, 1, "R9");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        // R10: write and output enable both low
        vec(0, 2'b11, 1, 1, 1, 2'b00, 2'b00, 2'b00, 0, "R2");
        vec(0, 2'b00, 0, 0, 0, 2'b00, 2'b00, 2'b00, 1, "R10");
        vec(0, 2'b00, 1, 0, 5, 2'b00, 2'b00, 2'b00, 0, "R6");
        vec(1, 2'b11, 1, 1, 0, 2'b00, 2'b00, 2'b00, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule